// File: doc/BRIEF.md
# Accumulator Store Preshift-and-Round Unit

This unit produces the 16-bit word that a DSP datapath writes back when it stores one of its two 40-bit accumulators to a register. A store command chooses the source accumulator and gives a signed 4-bit preshift code. It also carries a flag that picks rounding or truncation. The unit scales the chosen accumulator by the preshift, keeps bits 31:16 of the scaled value, and can round that word before it leaves. A separate mode input, which is not part of the command, sets the rounding style: conventional (round half up) or convergent (round half to even).

Each command takes one cycle. The result and a one-cycle valid strobe appear on the clock edge that accepts the command. Between commands the output word keeps its last value. The unit does not generate addresses, does not hold the register file and does not saturate the stored word.

Top module: `acc_store_unit`

## Requirements
- R1: `cmd_acc_sel` = 0 takes `acc_a` as the source and `cmd_acc_sel` = 1 takes `acc_b`. The accumulator that is not selected has no effect on the result.
- R2: `cmd_shift` is read as a two's-complement value from -8 to +7. A negative code shifts the accumulator left by its magnitude, and zeros enter at bit 0. Bits that leave bit 39 are lost.
- R3: A positive code shifts the accumulator right arithmetically by the code. Copies of accumulator bit 39 enter from the top.
- R4: The result is bits 31:16 of the shifted value. When `cmd_round` = 0, bits 15:0 are discarded and nothing is added.
- R5: When `cmd_round` = 1 and `round_mode` = 0 (conventional), the word is incremented exactly when bit 15 of the shifted value is 1.
- R6: When `cmd_round` = 1 and `round_mode` = 1 (convergent), the rule is the same as R5 except when bits 15:0 equal 0x8000. In that case the word is incremented only if bit 16 is 1.
- R7: A rounding increment of 0xFFFF wraps to 0x0000 and does not saturate.
- R8: `store_valid` is high for exactly the one cycle after each clock edge on which `cmd_valid` was high. The matching word is on `store_word` in that same cycle. Commands may arrive on consecutive cycles.
- R9: While `rst_n` is low, `store_valid` and `store_word` are 0.
- R10: On an edge where `cmd_valid` is low, `store_word` keeps its value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_a | input | 40 | Accumulator A contents |
| acc_b | input | 40 | Accumulator B contents |
| cmd_valid | input | 1 | A store command is present this cycle |
| cmd_acc_sel | input | 1 | 0 selects accumulator A, 1 selects accumulator B |
| cmd_shift | input | 4 | Signed preshift code: negative shifts left, positive shifts right |
| cmd_round | input | 1 | 1 rounds the word, 0 truncates it |
| round_mode | input | 1 | 0 selects conventional rounding, 1 selects convergent rounding |
| store_valid | output | 1 | Result strobe |
| store_word | output | 16 | Stored word |

## Verification
Preshift and rounding act in the same cycle. This matters most when a left shift moves a value into the tie position, so that the convergent rule has to look at a bit that the shift has just placed there. It also matters when the increment that follows a shift wraps at 0xFFFF. The vector table provokes these cases with directed values, for example 0x1800 shifted left by 4 under convergent rounding, and with all-ones words. A sweep over all sixteen shift codes and both rounding styles then compares each output with a bench model. That model adds a half-LSB and then corrects ties, which differs from the way the design decides its increment.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;

  localparam int ACC_W    = 40;
  localparam int WORD_W   = 16;
  localparam int CODE_W   = 4;
  localparam int WORD_LSB = 16;

  typedef enum logic {
    RND_CONVENTIONAL = 1'b0,
    RND_CONVERGENT   = 1'b1
  } rnd_mode_e;

  // Decide whether the kept word gets +1.
  // half: first discarded bit, rest_zero: all lower discarded bits are 0,
  // keep_lsb: least significant bit of the kept word.
  function automatic logic round_increment(logic en, rnd_mode_e mode,
                                           logic keep_lsb, logic half,
                                           logic rest_zero);
    logic inc;
    if (!en)
      inc = 1'b0;
    else if (mode == RND_CONVERGENT && half && rest_zero)
      inc = keep_lsb;
    else
      inc = half;
    return inc;
  endfunction

endpackage

// File: rtl/acc_src_mux.sv
module acc_src_mux #(
  parameter int ACC_W = acc_store_pkg::ACC_W
) (
  input  logic             sel,
  input  logic [ACC_W-1:0] src0,
  input  logic [ACC_W-1:0] src1,
  output logic [ACC_W-1:0] picked
);
  always_comb picked = sel ? src1 : src0;
endmodule

// File: rtl/acc_preshifter.sv
module acc_preshifter #(
  parameter int ACC_W  = acc_store_pkg::ACC_W,
  parameter int CODE_W = acc_store_pkg::CODE_W
) (
  input  logic [ACC_W-1:0]  value_in,
  input  logic [CODE_W-1:0] code,
  output logic [ACC_W-1:0]  value_out,
  output logic              dir_left
);
  localparam int STAGES = CODE_W;

  logic [CODE_W-1:0] magnitude;
  logic [ACC_W-1:0]  stage [STAGES+1];

  always_comb begin
    dir_left  = code[CODE_W-1];
    magnitude = dir_left ? (~code + 1'b1) : code;
  end

  assign stage[0] = value_in;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      localparam int AMT = 1 << k;
      logic [ACC_W-1:0] shl_v;
      logic [ACC_W-1:0] shr_v;
      assign shl_v = {stage[k][ACC_W-1-AMT:0], {AMT{1'b0}}};
      assign shr_v = {{AMT{stage[k][ACC_W-1]}}, stage[k][ACC_W-1:AMT]};
      assign stage[k+1] = !magnitude[k] ? stage[k] : (dir_left ? shl_v : shr_v);
    end
  endgenerate

  assign value_out = stage[STAGES];
endmodule

// File: rtl/acc_word_rounder.sv
module acc_word_rounder #(
  parameter int ACC_W    = acc_store_pkg::ACC_W,
  parameter int WORD_W   = acc_store_pkg::WORD_W,
  parameter int WORD_LSB = acc_store_pkg::WORD_LSB
) (
  input  logic                    [ACC_W-1:0]  shifted,
  input  logic                                 round_en,
  input  acc_store_pkg::rnd_mode_e             mode,
  output logic                    [WORD_W-1:0] word,
  output logic                                 inc,
  output logic                                 tie,
  output logic                                 keep_lsb
);
  localparam int HI_MSB = WORD_LSB + WORD_W - 1;

  logic [WORD_W-1:0]   hi;
  logic [WORD_LSB-1:0] frac;
  logic                half;
  logic                rest_zero;

  always_comb begin
    hi        = shifted[HI_MSB:WORD_LSB];
    frac      = shifted[WORD_LSB-1:0];
    half      = frac[WORD_LSB-1];
    rest_zero = ~|frac[WORD_LSB-2:0];
    keep_lsb  = hi[0];
    tie       = half && rest_zero;
    inc       = acc_store_pkg::round_increment(round_en, mode, keep_lsb, half, rest_zero);
    word      = hi + {{(WORD_W-1){1'b0}}, inc};
  end
endmodule

// File: rtl/acc_store_unit.sv
module acc_store_unit #(
  parameter int ACC_W    = acc_store_pkg::ACC_W,
  parameter int WORD_W   = acc_store_pkg::WORD_W,
  parameter int CODE_W   = acc_store_pkg::CODE_W,
  parameter int WORD_LSB = acc_store_pkg::WORD_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  acc_a,
  input  logic [ACC_W-1:0]  acc_b,
  input  logic              cmd_valid,
  input  logic              cmd_acc_sel,
  input  logic [CODE_W-1:0] cmd_shift,
  input  logic              cmd_round,
  input  logic              round_mode,
  output logic              store_valid,
  output logic [WORD_W-1:0] store_word
);
  localparam int HI_MSB = WORD_LSB + WORD_W - 1;

  logic [ACC_W-1:0]  src_acc;
  logic [ACC_W-1:0]  shifted_acc;
  logic              shift_left;
  logic [WORD_W-1:0] next_word;
  logic              round_inc;
  logic              tie_seen;
  logic              kept_lsb;
  acc_store_pkg::rnd_mode_e mode_sel;

  assign mode_sel = acc_store_pkg::rnd_mode_e'(round_mode);

  acc_src_mux #(.ACC_W(ACC_W)) u_mux (
    .sel(cmd_acc_sel), .src0(acc_a), .src1(acc_b), .picked(src_acc)
  );

  acc_preshifter #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_shift (
    .value_in(src_acc), .code(cmd_shift),
    .value_out(shifted_acc), .dir_left(shift_left)
  );

  acc_word_rounder #(.ACC_W(ACC_W), .WORD_W(WORD_W), .WORD_LSB(WORD_LSB)) u_round (
    .shifted(shifted_acc), .round_en(cmd_round), .mode(mode_sel),
    .word(next_word), .inc(round_inc), .tie(tie_seen), .keep_lsb(kept_lsb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_valid <= 1'b0;
      store_word  <= '0;
    end else begin
      store_valid <= cmd_valid;
      if (cmd_valid) store_word <= next_word;
    end
  end

  // R8: strobe follows each accepted command by one edge
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> store_valid);
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !store_valid);

  // R10: word held while idle
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(store_word));

  // R4: truncation never adds
  a_r4_trunc_no_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_round) |-> !round_inc);

  // R6: convergent tie with even kept word does not round up
  a_r6_tie_even: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_round && round_mode && tie_seen && !kept_lsb) |-> !round_inc);

  // R5: any increment needs the half bit of the shifted value
  a_r5_inc_needs_half: assert property (@(posedge clk) disable iff (!rst_n)
    round_inc |-> shifted_acc[WORD_LSB-1]);

  // R1: zero shift, truncate copies the selected accumulator's middle word
  a_r1_plain_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_shift == '0 && !cmd_round) |=>
      store_word == $past(cmd_acc_sel ? acc_b[HI_MSB:WORD_LSB] : acc_a[HI_MSB:WORD_LSB]));

  // R3: a right shift of a negative accumulator keeps bit 39 set
  a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !shift_left && src_acc[ACC_W-1]) |-> shifted_acc[ACC_W-1]);
endmodule

// File: tb/test_acc_store_unit.sv
`timescale 1ns/1ps
module test_acc_store_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] acc_a = '0;
  logic [39:0] acc_b = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_acc_sel = 1'b0;
  logic [3:0]  cmd_shift = '0;
  logic        cmd_round = 1'b0;
  logic        round_mode = 1'b0;
  logic        store_valid;
  logic [15:0] store_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  acc_store_unit i_acc_store_unit (
    .clk(clk), .rst_n(rst_n), .acc_a(acc_a), .acc_b(acc_b),
    .cmd_valid(cmd_valid), .cmd_acc_sel(cmd_acc_sel), .cmd_shift(cmd_shift),
    .cmd_round(cmd_round), .round_mode(round_mode),
    .store_valid(store_valid), .store_word(store_word)
  );

  // entry: {req, sel, acc, code, rnd, mode, expected}
  localparam int NV = 17;
  localparam logic [66:0] VECS [NV] = '{
    {4'd4, 1'b0, 40'h00_1234_5678, 4'h0, 1'b0, 1'b0, 16'h1234},  // R4 plain
    {4'd1, 1'b1, 40'h00_1234_5678, 4'h0, 1'b0, 1'b0, 16'h1234},  // R1 source B
    {4'd5, 1'b0, 40'h00_1234_8000, 4'h0, 1'b1, 1'b0, 16'h1235},  // R5 half up
    {4'd6, 1'b1, 40'h00_1234_8000, 4'h0, 1'b1, 1'b1, 16'h1234},  // R6 tie even stays
    {4'd6, 1'b0, 40'h00_1235_8000, 4'h0, 1'b1, 1'b1, 16'h1236},  // R6 tie odd rises
    {4'd6, 1'b1, 40'h00_1234_8001, 4'h0, 1'b1, 1'b1, 16'h1235},  // R6 above tie
    {4'd3, 1'b0, 40'hFF_8000_0000, 4'h4, 1'b0, 1'b0, 16'hF800},  // R3 sign fill
    {4'd3, 1'b0, 40'h00_8000_0000, 4'h4, 1'b0, 1'b0, 16'h0800},  // R3 zero fill from bit 39
    {4'd2, 1'b1, 40'h00_0000_1234, 4'hC, 1'b0, 1'b0, 16'h0001},  // R2 left 4
    {4'd2, 1'b0, 40'h00_0012_3456, 4'h8, 1'b0, 1'b0, 16'h1234},  // R2 left 8
    {4'd2, 1'b1, 40'h12_3456_789A, 4'h8, 1'b0, 1'b0, 16'h5678},  // R2 top bits lost
    {4'd3, 1'b0, 40'h00_0080_0000, 4'h7, 1'b0, 1'b0, 16'h0001},  // R3 right 7
    {4'd7, 1'b0, 40'h00_FFFF_8000, 4'h0, 1'b1, 1'b0, 16'h0000},  // R7 wrap
    {4'd6, 1'b1, 40'h00_0000_1800, 4'hC, 1'b1, 1'b1, 16'h0002},  // R6 tie after left shift
    {4'd7, 1'b0, 40'hFF_FFFF_FFFF, 4'h0, 1'b1, 1'b1, 16'h0000},  // R7 wrap convergent
    {4'd5, 1'b0, 40'h00_1234_7FFF, 4'h0, 1'b1, 1'b0, 16'h1234},  // R5 below half
    {4'd4, 1'b1, 40'h00_1234_FFFF, 4'h0, 1'b0, 1'b1, 16'h1234}   // R4 truncation drops
  };

  function automatic logic [15:0] model(logic [39:0] a, logic [3:0] code, bit rnd, bit conv);
    int amt;
    logic [39:0] s;
    logic [39:0] sum;
    logic [15:0] w;
    amt = $signed(code);
    if (amt < 0) s = a << (-amt);
    else         s = 40'($signed(a) >>> amt);
    sum = s + 40'h0000_8000;
    w = rnd ? sum[31:16] : s[31:16];
    if (rnd && conv && s[15:0] == 16'h8000 && !s[16]) w = s[31:16];
    return w;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(bit sel, logic [39:0] acc, logic [3:0] code, bit rnd, bit mode);
    @(negedge clk);
    acc_a       = sel ? ~acc : acc;
    acc_b       = sel ? acc : ~acc;
    cmd_acc_sel = sel;
    cmd_shift   = code;
    cmd_round   = rnd;
    round_mode  = mode;
    cmd_valid   = 1'b1;
    @(negedge clk);
    cmd_valid   = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [39:0] sweep_acc [4];
    sweep_acc[0] = 40'h00_1234_8000;
    sweep_acc[1] = 40'hFF_8765_0800;
    sweep_acc[2] = 40'h7F_FFFF_FFFF;
    sweep_acc[3] = 40'h80_0000_0180;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 valid", {15'b0, store_valid}, 16'h0000);
    check("R9 word", store_word, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [66:0] v;
      v = VECS[i];
      apply(v[62], v[61:22], v[21:18], v[17], v[16]);
      check($sformatf("R%0d vec%0d", v[66:63], i), store_word, v[15:0]);
      check("R8 strobe", {15'b0, store_valid}, 16'h0001);
    end

    // R8: strobe drops one cycle later
    @(negedge clk);
    check("R8 strobe low", {15'b0, store_valid}, 16'h0000);

    // R10: changing inputs while idle does not touch the word
    acc_a = 40'h00_AAAA_0000; acc_b = 40'h00_BBBB_0000;
    cmd_shift = 4'h3; cmd_round = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 hold", store_word, 16'h1234);

    // R8: back-to-back commands
    @(negedge clk);
    acc_a = 40'h00_1111_0000; acc_b = 40'h00_2222_0000;
    cmd_shift = 4'h0; cmd_round = 1'b0; cmd_acc_sel = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    check("R8 first", store_word, 16'h1111);
    cmd_acc_sel = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 second", store_word, 16'h2222);
    check("R8 second strobe", {15'b0, store_valid}, 16'h0001);

    // R2 R3 R5 R6: sweep all codes and styles against the model
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 16; c++)
        for (int r = 0; r < 4; r++) begin
          apply(r[0], sweep_acc[a], 4'(c), r[1], r[0]);
          check(c >= 8 ? "R2 sweep" : "R3 sweep", store_word,
                model(sweep_acc[a], 4'(c), r[1], r[0]));
        end

    // R9: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 word after reset", store_word, 16'h0000);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule